// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches every linear address that the core presents, from instruction fetch and from data loads and stores, and compares it against four programmable breakpoint addresses. Each breakpoint has its own enable bit, an access-type selector and a length selector in a shared control register. When an enabled breakpoint matches an access of the selected kind, the block raises a one-cycle debug-fault pulse and sets that breakpoint's sticky bit in a status register. Software clears the sticky bits by writing the status register. Comparison always uses linear addresses, so paging has no effect on it.

A resume flag lets a debug handler return to the faulting instruction without re-triggering. While the flag is set, matches raise no fault and record no status. The core sets the flag through a dedicated input. Each retiring instruction clears it, unless the core marks that instruction as one that restores the flags image itself, such as an interrupt return or a flags pop.

Registers are reached through a small indexed port. Indices 0 to 3 hold the breakpoint addresses, index 4 is the status register and index 5 is the control register. Control layout: bits 3:0 are the enables for breakpoints 0 to 3. For breakpoint k, bits 8+4k+1:8+4k hold the access type and bits 8+4k+3:8+4k+2 hold the length. Every other control bit reads as zero.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset, all four address registers, the control register and the status register read zero, `resumeFlag` is 0 and `debugFault` is 0.
- R2: A write with `regWrEn` high loads index 0..3, 4 or 5 at the clock edge. Reads on `regRdData` are combinational from `regIdx`. Indices 6 and 7 read zero, and writes to them change nothing.
- R3: With length code 00 (one byte), a breakpoint matches only when all 32 address bits are equal.
- R4: Length code 01 (two bytes) ignores address bit 0 in the compare. Length codes 10 and 11 (four bytes) ignore bits 1:0.
- R5: Type code 00 matches only fetches, 01 only data writes, 11 data reads or writes, and 10 never matches. On `accKind`, 00 is fetch, 01 is write, 10 is read and 11 matches nothing.
- R6: A breakpoint whose enable bit is 0 raises no fault and sets no status bit.
- R7: A matching access sampled at edge N drives `debugFault` high for the cycle after edge N. It stays high only while matching accesses continue.
- R8: Status bit k (bits 3:0) is set on an unsuppressed match of breakpoint k. Several bits can be set by one access. The bits stay set until software writes index 4, which replaces them with bits 3:0 of the written data.
- R9: While `resumeFlag` is 1, matches raise no fault and set no status bit.
- R10: A `resumeSet` pulse sets `resumeFlag`. A retire with `retireKeepsFlag` low clears it. A retire with `retireKeepsFlag` high leaves it unchanged. A set in the same cycle as a retire wins.
- R11: When a status write and a match occur in the same cycle, the result is the written value ORed with the new match bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regIdx | input | 3 | Register index for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regIdx` |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | 32 | Linear address of the access |
| accKind | input | 2 | 00 fetch, 01 write, 10 read, 11 none |
| resumeSet | input | 1 | Sets the resume flag |
| retireValid | input | 1 | An instruction retires this cycle |
| retireKeepsFlag | input | 1 | The retiring instruction restores flags itself |
| debugFault | output | 1 | Registered debug-fault pulse |
| resumeFlag | output | 1 | Current resume flag |

## Verification
The assertions check these rules on every cycle:
- status bits never drop without a status write;
- the resume flag follows the retire rules;
- no fault or status bit appears while the flag is set;
- a reserved type code never produces a hit;
- address writes land.

Only the bench scenarios can show that the masks match the chosen length and that each type code selects the right access kinds. The same holds for combined hits on two breakpoints and for the priority of a match over a status clear in the same cycle. Each of these needs planned address and type choices and known expected values.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NUM_BP = 4;
  localparam int FIELD_BASE = 8;
  localparam int FIELD_STRIDE = 4;
  localparam logic [2:0] IDX_STATUS = 3'd4;
  localparam logic [2:0] IDX_CTRL = 3'd5;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_NONE  = 2'b11
  } accKind_e;

  typedef enum logic [1:0] {
    RW_EXEC  = 2'b00,
    RW_WRITE = 2'b01,
    RW_RSVD  = 2'b10,
    RW_RDWR  = 2'b11
  } rwSel_e;

  typedef struct packed {
    logic [NUM_BP-1:0]      addrLoad;
    logic [NUM_BP-1:0]      bpEnable;
    logic [NUM_BP-1:0][1:0] rwSel;
    logic [NUM_BP-1:0][1:0] lenSel;
  } dpStrobe_t;
endpackage

// File: rtl/bkpt_datapath.sv
module bkpt_datapath
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobe_t                      strobe,
  input  logic [ADDR_W-1:0]              wrData,
  input  logic                           accValid,
  input  logic [ADDR_W-1:0]              accAddr,
  input  logic [1:0]                     accKind,
  output logic [NUM_BP-1:0][ADDR_W-1:0]  addrRegs,
  output logic [NUM_BP-1:0]              hitVec
);

  for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
    logic [ADDR_W-1:0] cmpMask;
    logic              addrEq;
    logic              typeOk;

    always_ff @(posedge clk) begin
      if (!rstN) addrRegs[k] <= '0;
      else if (strobe.addrLoad[k]) addrRegs[k] <= wrData;
    end

    always_comb begin
      cmpMask = '1;
      if (strobe.lenSel[k] == 2'b01) cmpMask[0] = 1'b0;
      else if (strobe.lenSel[k][1]) cmpMask[1:0] = 2'b00;
      addrEq = (((accAddr ^ addrRegs[k]) & cmpMask) == '0);
    end

    always_comb begin
      case (rwSel_e'(strobe.rwSel[k]))
        RW_EXEC:  typeOk = (accKind == ACC_FETCH);
        RW_WRITE: typeOk = (accKind == ACC_WRITE);
        RW_RDWR:  typeOk = (accKind == ACC_WRITE) || (accKind == ACC_READ);
        default:  typeOk = 1'b0;
      endcase
    end

    assign hitVec[k] = accValid && strobe.bpEnable[k] && addrEq && typeOk;

    // R5: reserved type code never produces a hit
    assert_rsvd_type_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.rwSel[k] == 2'b10) |-> !hitVec[k]);

    // R2: an address write lands at the next edge
    assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.addrLoad[k] |=> (addrRegs[k] == $past(wrData)));
  end

endmodule

// File: rtl/bkpt_control.sv
module bkpt_control
  import bkpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [IDX_W-1:0]               regIdx,
  input  logic [DATA_W-1:0]              regWrData,
  output logic [DATA_W-1:0]              regRdData,
  input  logic [NUM_BP-1:0][DATA_W-1:0]  addrRegs,
  input  logic [NUM_BP-1:0]              hitVec,
  input  logic                           resumeSet,
  input  logic                           retireValid,
  input  logic                           retireKeepsFlag,
  output dpStrobe_t                      strobe,
  output logic                           debugFault,
  output logic                           resumeFlag
);

  localparam int BP_IDX_W = $clog2(NUM_BP);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'(((64'd1 << NUM_BP) - 64'd1) |
            (((64'd1 << (FIELD_STRIDE * NUM_BP)) - 64'd1) << FIELD_BASE));

  logic [DATA_W-1:0] ctrlReg;
  logic [NUM_BP-1:0] statusReg;
  logic [NUM_BP-1:0] recordVec;
  logic [NUM_BP-1:0] statusNext;
  logic              rfQ;
  logic              faultQ;
  logic              statusWr;
  logic              ctrlWr;

  assign statusWr = regWrEn && (regIdx == IDX_W'(IDX_STATUS));
  assign ctrlWr   = regWrEn && (regIdx == IDX_W'(IDX_CTRL));

  always_comb begin
    for (int k = 0; k < NUM_BP; k++) begin
      strobe.addrLoad[k] = regWrEn && (regIdx == IDX_W'(k));
      strobe.bpEnable[k] = ctrlReg[k];
      strobe.rwSel[k]    = ctrlReg[FIELD_BASE + FIELD_STRIDE*k +: 2];
      strobe.lenSel[k]   = ctrlReg[FIELD_BASE + FIELD_STRIDE*k + 2 +: 2];
    end
  end

  assign recordVec  = hitVec & {NUM_BP{!rfQ}};
  assign statusNext = (statusWr ? regWrData[NUM_BP-1:0] : statusReg) | recordVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      statusReg <= '0;
      faultQ    <= 1'b0;
      rfQ       <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= regWrData & CTRL_MASK;
      statusReg <= statusNext;
      faultQ    <= |recordVec;
      if (resumeSet) rfQ <= 1'b1;
      else if (retireValid && !retireKeepsFlag) rfQ <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regIdx < IDX_W'(NUM_BP)) regRdData = addrRegs[regIdx[BP_IDX_W-1:0]];
    else if (regIdx == IDX_W'(IDX_STATUS)) regRdData = DATA_W'(statusReg);
    else if (regIdx == IDX_W'(IDX_CTRL)) regRdData = ctrlReg;
  end

  assign debugFault = faultQ;
  assign resumeFlag = rfQ;

  // R8: status bits only drop through a software write
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !statusWr |=> ((statusReg & $past(statusReg)) == $past(statusReg)));

  // R10: plain retire clears the flag
  assert_rf_clear_on_retire_R10: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && !retireKeepsFlag && !resumeSet) |=> !rfQ);

  // R10: flag-restoring retire keeps the flag
  assert_rf_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && retireKeepsFlag && rfQ) |=> rfQ);

  // R9: no fault follows a cycle with the flag set
  assert_fault_suppressed_R9: assert property (@(posedge clk) disable iff (!rstN)
    debugFault |-> !$past(rfQ));

  // R9: no new status bit while the flag is set
  assert_no_record_under_rf_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rfQ && !statusWr) |=> ((statusReg & ~$past(statusReg)) == '0));

  // R7: a fault always leaves a recorded status bit
  assert_fault_has_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    debugFault |-> (statusReg != '0));

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accKind,
  input  logic              resumeSet,
  input  logic              retireValid,
  input  logic              retireKeepsFlag,
  output logic              debugFault,
  output logic              resumeFlag
);

  dpStrobe_t                      strobe;
  logic [NUM_BP-1:0][ADDR_W-1:0]  addrRegs;
  logic [NUM_BP-1:0]              hitVec;

  bkpt_datapath #(.ADDR_W(ADDR_W)) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .accValid (accValid),
    .accAddr  (accAddr),
    .accKind  (accKind),
    .addrRegs (addrRegs),
    .hitVec   (hitVec)
  );

  bkpt_control #(.DATA_W(ADDR_W), .IDX_W(IDX_W)) control_i (
    .clk             (clk),
    .rstN            (rstN),
    .regWrEn         (regWrEn),
    .regIdx          (regIdx),
    .regWrData       (regWrData),
    .regRdData       (regRdData),
    .addrRegs        (addrRegs),
    .hitVec          (hitVec),
    .resumeSet       (resumeSet),
    .retireValid     (retireValid),
    .retireKeepsFlag (retireKeepsFlag),
    .strobe          (strobe),
    .debugFault      (debugFault),
    .resumeFlag      (resumeFlag)
  );

endmodule

// File: tb/bkpt_match_unit_tb_top.sv
module bkpt_match_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regIdx;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        accValid;
  logic [31:0] accAddr;
  logic [1:0]  accKind;
  logic        resumeSet;
  logic        retireValid;
  logic        retireKeepsFlag;
  logic        debugFault;
  logic        resumeFlag;

  int nChecks = 0;
  int nFail = 0;

  typedef struct {
    logic       expFault;
    logic [3:0] expStatus;
    string      req;
  } item_t;
  item_t sbQ[$];

  always #10 clk = ~clk;

  bkpt_match_unit dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIdx(regIdx),
    .regWrData(regWrData), .regRdData(regRdData), .accValid(accValid),
    .accAddr(accAddr), .accKind(accKind), .resumeSet(resumeSet),
    .retireValid(retireValid), .retireKeepsFlag(retireKeepsFlag),
    .debugFault(debugFault), .resumeFlag(resumeFlag)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  // monitor: pops one expected item per cycle after the access edge
  always @(negedge clk) begin
    item_t it;
    if (sbQ.size() > 0) begin
      it = sbQ.pop_front();
      check(it.req, "debugFault", 32'(debugFault), 32'(it.expFault));
      check(it.req, "status", 32'(regRdData[3:0]), 32'(it.expStatus));
    end
  end

  task automatic regWrite(input logic [2:0] idx, input logic [31:0] data);
    regWrEn = 1'b1; regIdx = idx; regWrData = data;
    @(posedge clk); @(negedge clk); #1;
    regWrEn = 1'b0; regIdx = 3'd4;
  endtask

  task automatic regRead(input logic [2:0] idx, input logic [31:0] exp, input string req);
    regIdx = idx; #1;
    check(req, "regRdData", regRdData, exp);
    regIdx = 3'd4;
  endtask

  task automatic doAccess(input logic [31:0] addr, input logic [1:0] kind,
                          input logic expFault, input logic [3:0] expStatus,
                          input string req);
    item_t it;
    accValid = 1'b1; accAddr = addr; accKind = kind;
    @(posedge clk);
    it.expFault = expFault; it.expStatus = expStatus; it.req = req;
    sbQ.push_back(it);
    @(negedge clk); #1;
    accValid = 1'b0;
  endtask

  task automatic accessAndClear(input logic [31:0] addr, input logic [1:0] kind,
                                input logic [3:0] wdata, input logic [3:0] expStatus,
                                input string req);
    item_t it;
    accValid = 1'b1; accAddr = addr; accKind = kind;
    regWrEn = 1'b1; regIdx = 3'd4; regWrData = 32'(wdata);
    @(posedge clk);
    it.expFault = 1'b1; it.expStatus = expStatus; it.req = req;
    sbQ.push_back(it);
    @(negedge clk); #1;
    accValid = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic idleCycle(input logic [3:0] expStatus, input string req);
    item_t it;
    @(posedge clk);
    it.expFault = 1'b0; it.expStatus = expStatus; it.req = req;
    sbQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic flagCycle(input logic setIt, input logic retIt, input logic keepIt);
    resumeSet = setIt; retireValid = retIt; retireKeepsFlag = keepIt;
    @(posedge clk); @(negedge clk); #1;
    resumeSet = 1'b0; retireValid = 1'b0; retireKeepsFlag = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regIdx = 3'd4; regWrData = '0;
    accValid = 1'b0; accAddr = '0; accKind = 2'b11;
    resumeSet = 1'b0; retireValid = 1'b0; retireKeepsFlag = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;

    // R1 reset state
    check("R1", "debugFault", 32'(debugFault), 32'd0);
    check("R1", "resumeFlag", 32'(resumeFlag), 32'd0);
    regRead(3'd0, 32'd0, "R1");
    regRead(3'd3, 32'd0, "R1");
    regRead(3'd4, 32'd0, "R1");
    regRead(3'd5, 32'd0, "R1");

    // R2 register port
    regWrite(3'd0, 32'h1000_0010);
    regWrite(3'd1, 32'h2000_0003);
    regWrite(3'd2, 32'h3000_0007);
    regWrite(3'd3, 32'h4000_0000);
    regRead(3'd0, 32'h1000_0010, "R2");
    regRead(3'd1, 32'h2000_0003, "R2");
    regRead(3'd2, 32'h3000_0007, "R2");
    regRead(3'd3, 32'h4000_0000, "R2");
    regWrite(3'd6, 32'hDEAD_BEEF);
    regRead(3'd6, 32'd0, "R2");
    regRead(3'd7, 32'd0, "R2");
    regRead(3'd0, 32'h1000_0010, "R2");
    // bp0 exec len1, bp1 write len2, bp2 rdwr len4, bp3 reserved type
    regWrite(3'd5, 32'hFFFF_FFFF & 32'h002F_500F);
    regRead(3'd5, 32'h002F_500F, "R2");

    // R3 exact compare, R5 fetch only, R7 pulse
    doAccess(32'h1000_0010, 2'b00, 1'b1, 4'h1, "R3");
    idleCycle(4'h1, "R7");
    doAccess(32'h1000_0011, 2'b00, 1'b0, 4'h1, "R3");
    doAccess(32'h1000_0010, 2'b01, 1'b0, 4'h1, "R5");
    regWrite(3'd4, 32'd0);
    regRead(3'd4, 32'd0, "R8");

    // R4 two-byte mask, R5 write only
    doAccess(32'h2000_0002, 2'b01, 1'b1, 4'h2, "R4");
    doAccess(32'h2000_0002, 2'b10, 1'b0, 4'h2, "R5");
    doAccess(32'h2000_0001, 2'b01, 1'b0, 4'h2, "R4");
    doAccess(32'h2000_0002, 2'b11, 1'b0, 4'h2, "R5");
    regWrite(3'd4, 32'd0);

    // R4 four-byte mask, R5 read-or-write
    doAccess(32'h3000_0004, 2'b10, 1'b1, 4'h4, "R4");
    doAccess(32'h3000_0005, 2'b01, 1'b1, 4'h4, "R5");
    doAccess(32'h3000_0007, 2'b00, 1'b0, 4'h4, "R5");
    doAccess(32'h3000_0008, 2'b10, 1'b0, 4'h4, "R4");
    regWrite(3'd4, 32'd0);

    // R5 reserved type never matches
    doAccess(32'h4000_0000, 2'b00, 1'b0, 4'h0, "R5");
    doAccess(32'h4000_0000, 2'b01, 1'b0, 4'h0, "R5");
    doAccess(32'h4000_0000, 2'b10, 1'b0, 4'h0, "R5");

    // R6 disabled breakpoint
    regWrite(3'd5, 32'h002F_500E);
    doAccess(32'h1000_0010, 2'b00, 1'b0, 4'h0, "R6");
    regWrite(3'd5, 32'h002F_500F);

    // R8 two breakpoints on one access
    regWrite(3'd1, 32'h3000_0004);
    doAccess(32'h3000_0004, 2'b01, 1'b1, 4'h6, "R8");
    idleCycle(4'h6, "R8");
    regWrite(3'd4, 32'd0);
    regRead(3'd4, 32'd0, "R8");

    // R10 / R9 resume flag
    flagCycle(1'b1, 1'b0, 1'b0);
    check("R10", "resumeFlag after set", 32'(resumeFlag), 32'd1);
    doAccess(32'h1000_0010, 2'b00, 1'b0, 4'h0, "R9");
    flagCycle(1'b0, 1'b1, 1'b1);
    check("R10", "resumeFlag after keep retire", 32'(resumeFlag), 32'd1);
    flagCycle(1'b0, 1'b1, 1'b0);
    check("R10", "resumeFlag after retire", 32'(resumeFlag), 32'd0);
    flagCycle(1'b1, 1'b1, 1'b0);
    check("R10", "resumeFlag set beats retire", 32'(resumeFlag), 32'd1);
    flagCycle(1'b0, 1'b1, 1'b0);
    check("R10", "resumeFlag cleared", 32'(resumeFlag), 32'd0);
    doAccess(32'h1000_0010, 2'b00, 1'b1, 4'h1, "R9");

    // R11 match beats a clearing write in the same cycle
    accessAndClear(32'h3000_0004, 2'b10, 4'h0, 4'h4, "R11");
    idleCycle(4'h4, "R11");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule